// File: doc/BRIEF.md
# Fractional-Increment PTP Time Counter

This block keeps a free-running time-of-day value in whole nanoseconds for IEEE 1588 timestamp logic. The running value sits in a 96-bit accumulator: 64 integer nanosecond bits on top of 32 fractional bits. Each clock it adds a programmable increment made of a small integer part and a 32-bit fraction, so a tick period that is not a whole number of nanoseconds still adds up exactly over time. The integer part drives the `tod_ns` output that timestamp capture logic samples.

Software uses a 32-bit register port. It can set the time, read it back, change the tick increment and switch counting on or off. Each 64-bit quantity is split into two 32-bit words. Writing the high word commits the low word staged before it, and reading the low word of the time freezes the high word for the read that follows, so split accesses never tear. A zero increment stops the clock, which is how an unsupported line rate is handled.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time reads 0, the increment reads 0 in both words and the enable bit reads 0.
- R2: Register addresses: 0 control (bit 0 = count enable), 1 time low word, 2 time high word, 3 increment fraction, 4 increment integer nanoseconds in bits 7:0. Unmapped reads return 0.
- R3: While enabled, each clock without a time commit adds the increment to the 96-bit accumulator, and `tod_ns` is its upper 64 bits. With an increment of 0x01_9999_9999 the time reads 7 after five ticks from a cleared accumulator, because the fraction is kept exactly.
- R4: With control bit 0 clear, the time holds its value.
- R5: An increment of zero holds the time even when enabled.
- R6: Writing the time low word alone does not change the time. Writing the time high word loads {high, staged low} at that clock edge, clears the fraction, and replaces that cycle's increment. Counting then continues from the new value.
- R7: A time commit takes effect while counting is disabled.
- R8: Writing the increment fraction alone changes neither the counting rate nor the value read back at address 3. The increment integer write commits both words together.
- R9: Reading address 1 returns the low 32 bits of the current time and captures its high 32 bits. A later read of address 2 returns the captured word, even if the time has carried into the high half since.
- R10: Read data and `rd_valid` appear exactly one clock after `rd_en`, and `rd_valid` lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| tod_ns | output | 64 | Current time in whole nanoseconds |

## Verification
The bench targets fractional carry with the 1.6 ns increment. A design that dropped the fraction would show 5 ns after five ticks instead of 7. It reads the time low word just before a 32-bit carry and the high word after it. A design without the snapshot would return the post-carry high word, 6 instead of 5. It writes only the low halves and checks that nothing moves: the time, the rate and the read-back value must all hold. Early commits would show up as a jump in `tod_ns` or a new increment. It also commits a time while fraction is pending and while counting is off. A stale fraction would show up one tick later as an extra nanosecond, and a load gated by the enable would never land.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL    = 3'd0,
      REG_TIME_LO = 3'd1,
      REG_TIME_HI = 3'd2,
      REG_INC_LO  = 3'd3,
      REG_INC_HI  = 3'd4
   } tod_reg_e;
endpackage

// File: rtl/ptp_tod_split_stage.sv
`timescale 1ns/1ps
// Two-word staging: the low word waits in a register, the high word commits.
// KEEP_VALUE=1 holds the committed value; KEEP_VALUE=0 presents it for one cycle.
module ptp_tod_split_stage #(
   parameter int unsigned LO_W       = 32,
   parameter int unsigned HI_W       = 32,
   parameter bit          KEEP_VALUE = 1'b0,
   localparam int unsigned VAL_W     = LO_W + HI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic [LO_W-1:0]  lo_data,
   input  logic [HI_W-1:0]  hi_data,
   output logic             commit,
   output logic [VAL_W-1:0] value
);
   logic [LO_W-1:0]  stage_lo_q;
   logic [VAL_W-1:0] joined;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stage_lo_q <= '0;
      else if (lo_we) stage_lo_q <= lo_data;
   end

   assign joined = {hi_data, stage_lo_q};
   assign commit = hi_we;

   generate
      if (KEEP_VALUE) begin : g_hold
         logic [VAL_W-1:0] held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     held_q <= '0;
            else if (hi_we) held_q <= joined;
         end
         assign value = held_q;

         // R8: only the high-word write changes the held value
         p_hold_until_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !hi_we |=> $stable(value));
         p_commit_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hi_we |=> value == {$past(hi_data), $past(stage_lo_q)});
      end else begin : g_pass
         assign value = joined;
      end
   endgenerate
endmodule

// File: rtl/ptp_tod_accum.sv
`timescale 1ns/1ps
// 96-bit fractional nanosecond accumulator.
module ptp_tod_accum #(
   parameter int unsigned INT_W     = 64,
   parameter int unsigned FRAC_W    = 32,
   parameter int unsigned INC_INT_W = 8,
   localparam int unsigned ACC_W    = INT_W + FRAC_W,
   localparam int unsigned INC_W    = INC_INT_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   input  logic             load,
   input  logic [INT_W-1:0] load_val,
   output logic [INT_W-1:0] tod
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_n;

   always_comb begin
      acc_n = acc_q;
      if (load)    acc_n = {load_val, {FRAC_W{1'b0}}};
      else if (en) acc_n = acc_q + ACC_W'(inc);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_n;
   end

   assign tod = acc_q[ACC_W-1:FRAC_W];

   // R3: counting never moves time backwards
   p_monotonic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |=> tod >= $past(tod));
   // R4: disabled clock holds
   p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(acc_q));
   // R5: zero increment freezes
   p_zero_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc == '0 && !load) |=> $stable(acc_q));
   // R6, R7: a commit loads the value and clears the fraction
   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tod == $past(load_val)) && (acc_q[FRAC_W-1:0] == '0));
endmodule

// File: rtl/ptp_tod_rdport.sv
`timescale 1ns/1ps
// Registered read mux with high-word snapshot taken on the low-word read.
module ptp_tod_rdport
   import ptp_tod_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TIME_W    = 64,
   parameter int unsigned FRAC_W    = 32,
   parameter int unsigned INC_INT_W = 8,
   localparam int unsigned INC_W    = INC_INT_W + FRAC_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   input  logic [TIME_W-1:0]     tod,
   input  logic                  ctrl_en,
   input  logic [INC_W-1:0]      inc,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_valid
);
   logic [DATA_W-1:0] snap_q;
   logic [DATA_W-1:0] inc_hi_word;
   logic [DATA_W-1:0] rdata_n;
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_valid_q;

   generate
      if (INC_INT_W < DATA_W) begin : g_pad
         assign inc_hi_word = {{(DATA_W-INC_INT_W){1'b0}}, inc[INC_W-1:FRAC_W]};
      end else begin : g_full
         assign inc_hi_word = inc[INC_W-1:FRAC_W];
      end
   endgenerate

   always_comb begin
      rdata_n = '0;
      case (rd_addr)
         REG_CTRL:    rdata_n = {{(DATA_W-1){1'b0}}, ctrl_en};
         REG_TIME_LO: rdata_n = tod[DATA_W-1:0];
         REG_TIME_HI: rdata_n = snap_q;
         REG_INC_LO:  rdata_n = inc[FRAC_W-1:0];
         REG_INC_HI:  rdata_n = inc_hi_word;
         default:     rdata_n = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q     <= '0;
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= rd_en;
         if (rd_en) rd_data_q <= rdata_n;
         if (rd_en && rd_addr == REG_TIME_LO) snap_q <= tod[TIME_W-1:DATA_W];
      end
   end

   assign rd_data  = rd_data_q;
   assign rd_valid = rd_valid_q;

   // R10: one-cycle read latency, no stray valids
   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_no_stray_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   // R9: low-word read returns the time seen at that edge
   p_lo_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == REG_TIME_LO) |=> rd_data == $past(tod[DATA_W-1:0]));
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TIME_W    = 64,
   parameter int unsigned FRAC_W    = 32,
   parameter int unsigned INC_INT_W = 8,
   localparam int unsigned INC_W    = INC_INT_W + FRAC_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_valid,
   output logic [TIME_W-1:0]     tod_ns
);
   generate
      if (TIME_W != 2 * DATA_W) begin : g_bad_time_w
         $error("TIME_W must be two data words");
      end
      if (FRAC_W != DATA_W) begin : g_bad_frac_w
         $error("FRAC_W must equal one data word");
      end
      if (INC_INT_W < 1 || INC_INT_W > DATA_W) begin : g_bad_inc_w
         $error("INC_INT_W must lie in 1..DATA_W");
      end
   endgenerate

   logic              en_q;
   logic              we_ctrl, we_time_lo, we_time_hi, we_inc_lo, we_inc_hi;
   logic              time_load;
   logic [TIME_W-1:0] time_val;
   logic              inc_commit;
   logic [INC_W-1:0]  inc_val;

   assign we_ctrl    = wr_en && (wr_addr == REG_CTRL);
   assign we_time_lo = wr_en && (wr_addr == REG_TIME_LO);
   assign we_time_hi = wr_en && (wr_addr == REG_TIME_HI);
   assign we_inc_lo  = wr_en && (wr_addr == REG_INC_LO);
   assign we_inc_hi  = wr_en && (wr_addr == REG_INC_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (we_ctrl) en_q <= wr_data[0];
   end

   ptp_tod_split_stage #(
      .LO_W(DATA_W), .HI_W(TIME_W - DATA_W), .KEEP_VALUE(1'b0)
   ) u_time_stage (
      .clk(clk), .rst_n(rst_n),
      .lo_we(we_time_lo), .hi_we(we_time_hi),
      .lo_data(wr_data), .hi_data(wr_data[TIME_W-DATA_W-1:0]),
      .commit(time_load), .value(time_val)
   );

   ptp_tod_split_stage #(
      .LO_W(FRAC_W), .HI_W(INC_INT_W), .KEEP_VALUE(1'b1)
   ) u_inc_stage (
      .clk(clk), .rst_n(rst_n),
      .lo_we(we_inc_lo), .hi_we(we_inc_hi),
      .lo_data(wr_data[FRAC_W-1:0]), .hi_data(wr_data[INC_INT_W-1:0]),
      .commit(inc_commit), .value(inc_val)
   );

   ptp_tod_accum #(
      .INT_W(TIME_W), .FRAC_W(FRAC_W), .INC_INT_W(INC_INT_W)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .en(en_q), .inc(inc_val),
      .load(time_load), .load_val(time_val), .tod(tod_ns)
   );

   ptp_tod_rdport #(
      .DATA_W(DATA_W), .TIME_W(TIME_W), .FRAC_W(FRAC_W), .INC_INT_W(INC_INT_W)
   ) u_rdport (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .tod(tod_ns), .ctrl_en(en_q), .inc(inc_val),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // R6: a time commit lands on the port one edge later
   p_time_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |=> tod_ns == $past(time_val));
   // R8: an increment fraction write alone leaves the increment unchanged
   p_inc_lo_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_inc_lo && !inc_commit) |=> $stable(inc_val));
   // R2: control bit follows its write
   p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_ctrl |=> en_q == $past(wr_data[0]));
endmodule

// File: tb/ptp_tod_counter_bench.sv
`timescale 1ns/1ps
module ptp_tod_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [63:0] tod_ns;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";
   logic [31:0] last_rd;
   logic [63:0] t_hold;

   always #2.5 clk = ~clk;

   ptp_tod_counter u_ptp_tod_counter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .tod_ns(tod_ns)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   logic [95:0] m_acc;
   logic [39:0] m_inc;
   logic [31:0] m_tlo, m_ilo, m_snap;
   logic        m_en;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc <= '0; m_inc <= '0; m_tlo <= '0; m_ilo <= '0;
         m_snap <= '0; m_en <= 1'b0;
      end else begin
         if (rd_en) begin
            case (rd_addr)
               3'd0: exp_q.push_back({31'd0, m_en});
               3'd1: exp_q.push_back(m_acc[63:32]);
               3'd2: exp_q.push_back(m_snap);
               3'd3: exp_q.push_back(m_inc[31:0]);
               3'd4: exp_q.push_back({24'd0, m_inc[39:32]});
               default: exp_q.push_back(32'd0);
            endcase
            tag_q.push_back(cur_req);
            if (rd_addr == 3'd1) m_snap <= m_acc[95:64];
         end
         if (wr_en && wr_addr == 3'd2) m_acc <= {wr_data, m_tlo, 32'd0};
         else if (m_en)                 m_acc <= m_acc + {56'd0, m_inc};
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_en  <= wr_data[0];
               3'd1: m_tlo <= wr_data;
               3'd3: m_ilo <= wr_data;
               3'd4: m_inc <= {wr_data[7:0], m_ilo};
               default: ;
            endcase
         end
      end
   end

   // monitor: scoreboard pop and continuous time compare
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk({cur_req, " time"}, tod_ns, m_acc[95:32]);
         if (rd_valid) begin
            if (exp_q.size() == 0) chk("R10 stray valid", 64'd1, 64'd0);
            else chk({tag_q.pop_front(), " read"}, {32'd0, rd_data}, {32'd0, exp_q.pop_front()});
         end else if (exp_q.size() != 0) begin
            chk("R10 missing valid", 64'd0, 64'd1);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R10 valid after one cycle", {63'd0, rd_valid}, 64'd1);
      last_rd = rd_data;
      @(negedge clk);
      chk("R10 single-cycle valid", {63'd0, rd_valid}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      cur_req = "R1";
      chk("R1 reset time", tod_ns, 64'd0);
      rd(3'd0); chk("R1 enable", {32'd0, last_rd}, 64'd0);
      rd(3'd3); chk("R1 inc frac", {32'd0, last_rd}, 64'd0);
      rd(3'd4); chk("R1 inc int", {32'd0, last_rd}, 64'd0);
      cur_req = "R2";
      rd(3'd6); chk("R2 unmapped", {32'd0, last_rd}, 64'd0);
      // R5 zero increment while enabled
      cur_req = "R5";
      wr(3'd0, 32'd1);
      rd(3'd0); chk("R2 enable bit", {32'd0, last_rd}, 64'd1);
      tick(4);
      chk("R5 frozen at zero inc", tod_ns, 64'd0);
      // R3 integer increment
      cur_req = "R3";
      wr(3'd3, 32'd0); wr(3'd4, 32'd1);
      tick(10);
      chk("R3 one ns per tick", tod_ns, 64'd10);
      // R8 staged fraction
      cur_req = "R8";
      wr(3'd3, 32'h9999_9999);
      rd(3'd3); chk("R8 frac not committed", {32'd0, last_rd}, 64'd0);
      tick(3);
      wr(3'd4, 32'd1);
      rd(3'd3); chk("R8 frac committed", {32'd0, last_rd}, 64'h9999_9999);
      rd(3'd4); chk("R8 int committed", {32'd0, last_rd}, 64'd1);
      // R3 fractional accumulation, 1.6 ns
      cur_req = "R3";
      wr(3'd1, 32'd0); wr(3'd2, 32'd0);
      chk("R6 load zero", tod_ns, 64'd0);
      tick(5);
      chk("R3 fraction carried", tod_ns, 64'd7);
      tick(20);
      // R4 disable holds
      cur_req = "R4";
      wr(3'd0, 32'd0);
      t_hold = tod_ns;
      tick(10);
      chk("R4 held while disabled", tod_ns, t_hold);
      // R6/R7 staged time write while disabled
      cur_req = "R7";
      wr(3'd1, 32'hFFFF_FFF0);
      chk("R6 low word alone no effect", tod_ns, t_hold);
      wr(3'd2, 32'd5);
      chk("R7 load while disabled", tod_ns, 64'h5_FFFF_FFF0);
      // R9 snapshot across a carry, 32 ns
      cur_req = "R9";
      wr(3'd3, 32'd0); wr(3'd4, 32'h20); wr(3'd0, 32'd1);
      rd(3'd1); chk("R9 low word", {32'd0, last_rd}, 64'hFFFF_FFF0);
      tick(3);
      chk("R9 time carried", {32'd0, tod_ns[63:32]}, 64'd6);
      rd(3'd2); chk("R9 snapshot high", {32'd0, last_rd}, 64'd5);
      // R6 commit while counting with fraction pending
      cur_req = "R6";
      wr(3'd3, 32'h9999_9999); wr(3'd4, 32'd1);
      tick(3);
      wr(3'd1, 32'h100);
      wr(3'd2, 32'd0);
      chk("R6 load while counting", tod_ns, 64'h100);
      tick(1);
      chk("R6 fraction cleared", tod_ns, 64'h101);
      tick(1);
      chk("R6 counting resumes", tod_ns, 64'h103);
      // R5 freeze by zero increment while enabled
      cur_req = "R5";
      wr(3'd3, 32'd0); wr(3'd4, 32'd0);
      t_hold = tod_ns;
      tick(8);
      chk("R5 frozen while enabled", tod_ns, t_hold);
      cur_req = "R10";
      rd(3'd1);
      tick(2);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule